// File: doc/BRIEF.md
# PCI Bridge Error Status and Interrupt Register

This block is the global error status and control word of a PCI host bridge. It records three error events as sticky flags: a stalled bus master, the parity-error line, and the system-error line. It combines them with per-event enables into one CPU interrupt line. Software reads the whole word through a 32-bit synchronous port and acknowledges an event by writing a one to the event's flag. Two read-only fields report the clock divide ratios of the host bus and the peripheral bus. The block takes these from strap pins in the first cycle after reset.

Each requesting master has a small watchdog. A master that holds the grant but leaves the bus idle for `IDLE_LIMIT` consecutive clocks is declared stalled. Its request is then masked from the arbiter and its FRAME# activity is no longer passed on. The mask holds until the master drops its request, the arbiter issues a soft-reset pulse, or a hard reset occurs. The register numbers bits from 0 at the most significant end. The requirements below give positions as conventional word bits, where bit 31 is the most significant.

Top module: `bridge_err_csr`

## Requirements
- R1: After reset, the status flags and enables read 0, the mark bit (word bit 0) reads 1, `irq_o` is 0 and no request is masked. While `rst_ni` is low the word reads 0x0000_0001.
- R2: The host-bus ratio (word bits 26:24) and the peripheral-bus ratio (word bits 18:16) are loaded once after reset from 2-bit straps: 00 gives 3'b001, 01 gives 3'b010, and 10 or 11 gives 3'b100. Later strap changes and CSR writes leave them unchanged.
- R3: The parity flag (word bit 29) sets when the active-low `perr_ni` is sampled low through a two-flop synchronizer. A one-cycle low pulse on `perr_ni` is visible on the third rising edge after it is driven, and the flag stays set afterwards.
- R4: The system-error flag (word bit 28) behaves the same way from `serr_ni`.
- R5: Writing 1 to a flag position clears that flag. Writing 0 leaves it unchanged.
- R6: When an event and a write-1-to-clear of the same flag fall in the same cycle, the flag stays set.
- R7: The enables are read/write at word bit 14 (stalled master), bit 13 (parity) and bit 12 (system error). `irq_o` is high exactly when some flag and its enable are both 1.
- R8: Once asserted, `irq_o` stays high until a CSR write clears the flag or its enable. The passage of time alone never drops it.
- R9: A requester that has `req_i` and `gnt_i` high while `frame_ni` stays high for `IDLE_LIMIT` consecutive clocks sets the stalled-master flag (word bit 30) on that clock and has its `req_masked_o` forced low. A cycle with `frame_ni` low restarts the count.
- R10: A masked requester is released when its `req_i` goes low, or immediately when `rst_ni` is asserted.
- R11: A one-cycle `arb_soft_rst_i` pulse releases all masks on the next clock and leaves the stalled-master flag unchanged.
- R12: `frame_ok_o` is high when `frame_ni` is low, unless a requester that is currently granted is masked.
- R13: Every bit other than the flags, enables, ratios and mark reads 0 and ignores writes. The mark bit is plain read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bridge clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| csr_wr_i | input | 1 | Write strobe for the status word |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Current status word |
| irq_o | output | 1 | CPU interrupt request |
| perr_ni | input | 1 | Parity-error line, active low, asynchronous |
| serr_ni | input | 1 | System-error line, active low, asynchronous |
| strap_hb_i | input | 2 | Host-bus ratio strap |
| strap_pb_i | input | 2 | Peripheral-bus ratio strap |
| req_i | input | NUM_REQ | External master requests |
| gnt_i | input | NUM_REQ | Grants issued by the arbiter |
| frame_ni | input | 1 | FRAME# line, active low |
| arb_soft_rst_i | input | 1 | Arbiter soft-reset pulse |
| req_masked_o | output | NUM_REQ | Requests passed on to the arbiter |
| frame_ok_o | output | 1 | FRAME# assertion accepted |

## Verification
The assertions assume three things about the inputs:
- `arb_soft_rst_i` is a pulse.
- `req_i`, `gnt_i` and `frame_ni` are synchronous to `clk_i`.
- Only software writes can remove a flag.

The error lines may arrive at any time, because the synchronizer absorbs them. The stimulus changes every synchronous input on the falling clock edge and holds the strap pins steady around a reset. The watchdog tests drive exactly `IDLE_LIMIT` idle cycles, and one fewer, so that the event fires on the expected edge.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int unsigned CSR_W        = 32;
  localparam int unsigned N_EV         = 3;
  localparam int unsigned EV_SE        = 0;
  localparam int unsigned EV_PE        = 1;
  localparam int unsigned EV_BM        = 2;
  localparam int unsigned STAT_LSB     = 28;
  localparam int unsigned EN_LSB       = 12;
  localparam int unsigned RATIO_W      = 3;
  localparam int unsigned RATIO_HB_LSB = 24;
  localparam int unsigned RATIO_PB_LSB = 16;
  localparam int unsigned MARK_POS     = 0;

  typedef logic [N_EV-1:0]    ev_vec_t;
  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [CSR_W-1:0]   word_t;

  function automatic ratio_t ratio_decode(input logic [1:0] sel);
    ratio_t r;
    case (sel)
      2'b00:   r = 3'b001;
      2'b01:   r = 3'b010;
      default: r = 3'b100;
    endcase
    return r;
  endfunction

  function automatic word_t live_mask();
    word_t m;
    m = '0;
    for (int e = 0; e < N_EV; e++) begin
      m[STAT_LSB + e] = 1'b1;
      m[EN_LSB + e]   = 1'b1;
    end
    m[MARK_POS] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/bec_sync_chain.sv
module bec_sync_chain #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bec_idle_watch.sv
module bec_idle_watch #(
  parameter int unsigned IDLE_LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic gnt_i,
  input  logic frame_ni,
  input  logic soft_rst_i,
  output logic evt_o,
  output logic locked_o
);
  localparam int unsigned CW = (IDLE_LIMIT > 2) ? $clog2(IDLE_LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(IDLE_LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_q, lock_d;
  logic          idle_cyc;

  assign idle_cyc = req_i & gnt_i & frame_ni & ~lock_q;
  assign evt_o    = idle_cyc & (cnt_q == LAST);

  always_comb begin
    if (!idle_cyc || soft_rst_i || evt_o) cnt_d = '0;
    else                                  cnt_d = cnt_q + 1'b1;

    if (soft_rst_i || !req_i) lock_d = 1'b0;
    else if (evt_o)           lock_d = 1'b1;
    else                      lock_d = lock_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign locked_o = lock_q;

  // R10: a dropped request always frees the requester
  p_release_on_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !req_i) |=> !lock_q);
  // R11: soft reset frees the requester
  p_soft_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !lock_q);
  // R9: a stall is reported once, not on back-to-back cycles
  p_single_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/bec_csr_core.sv
module bec_csr_core
  import bec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  word_t      wdata_i,
  input  ev_vec_t    ev_set_i,
  input  logic [1:0] strap_hb_i,
  input  logic [1:0] strap_pb_i,
  output word_t      rdata_o,
  output logic       irq_o
);
  ev_vec_t stat_q, stat_d, en_q, en_d, clr_hit;
  logic    mark_q, mark_d;
  ratio_t  hb_q, hb_d, pb_q, pb_d;
  logic    loaded_q;
  logic    ratio_ld;
  logic    unused_wbits;

  assign ratio_ld     = ~loaded_q;
  assign unused_wbits = ^(wdata_i & ~live_mask());

  always_comb begin
    for (int e = 0; e < N_EV; e++) begin
      clr_hit[e] = wr_i & wdata_i[STAT_LSB + e];
    end
    stat_d = (stat_q & ~clr_hit) | ev_set_i;
    en_d   = wr_i ? wdata_i[EN_LSB +: N_EV] : en_q;
    mark_d = wr_i ? wdata_i[MARK_POS] : mark_q;
    hb_d   = ratio_ld ? ratio_decode(strap_hb_i) : hb_q;
    pb_d   = ratio_ld ? ratio_decode(strap_pb_i) : pb_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q   <= '0;
      en_q     <= '0;
      mark_q   <= 1'b1;
      hb_q     <= '0;
      pb_q     <= '0;
      loaded_q <= 1'b0;
    end else begin
      stat_q   <= stat_d;
      en_q     <= en_d;
      mark_q   <= mark_d;
      hb_q     <= hb_d;
      pb_q     <= pb_d;
      loaded_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int e = 0; e < N_EV; e++) begin
      rdata_o[STAT_LSB + e] = stat_q[e];
      rdata_o[EN_LSB + e]   = en_q[e];
    end
    rdata_o[RATIO_HB_LSB +: RATIO_W] = hb_q;
    rdata_o[RATIO_PB_LSB +: RATIO_W] = pb_q;
    rdata_o[MARK_POS]                = mark_q;
  end

  assign irq_o = |(stat_q & en_q);

  for (genvar e = 0; e < N_EV; e++) begin : g_chk
    // R6: an event always lands, even against a clear
    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_set_i[e] |=> stat_q[e]);
    // R5: only a write of one removes a flag
    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[e] && !(wr_i && wdata_i[STAT_LSB + e])) |=> stat_q[e]);
  end
  // R8: without a write the interrupt cannot fall
  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_i) |=> irq_o);
  // R2: ratio fields frozen once loaded
  p_ratio_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> ($stable(hb_q) && $stable(pb_q)));
endmodule

// File: rtl/bridge_err_csr.sv
module bridge_err_csr
  import bec_pkg::*;
#(
  parameter int unsigned NUM_REQ     = 2,
  parameter int unsigned IDLE_LIMIT  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_wr_i,
  input  logic [31:0]        csr_wdata_i,
  output logic [31:0]        csr_rdata_o,
  output logic               irq_o,
  input  logic               perr_ni,
  input  logic               serr_ni,
  input  logic [1:0]         strap_hb_i,
  input  logic [1:0]         strap_pb_i,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [NUM_REQ-1:0] gnt_i,
  input  logic               frame_ni,
  input  logic               arb_soft_rst_i,
  output logic [NUM_REQ-1:0] req_masked_o,
  output logic               frame_ok_o
);
  logic [1:0]         rst_pipe_q;
  logic               rst_n_int;
  logic [1:0]         err_sync_n;
  logic [NUM_REQ-1:0] stall_evt, locked;
  ev_vec_t            ev_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  bec_sync_chain #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_err_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .d_i   ({perr_ni, serr_ni}),
    .q_o   (err_sync_n)
  );

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_watch
    bec_idle_watch #(.IDLE_LIMIT(IDLE_LIMIT)) u_watch (
      .clk_i     (clk_i),
      .rst_ni    (rst_n_int),
      .req_i     (req_i[r]),
      .gnt_i     (gnt_i[r]),
      .frame_ni  (frame_ni),
      .soft_rst_i(arb_soft_rst_i),
      .evt_o     (stall_evt[r]),
      .locked_o  (locked[r])
    );
  end

  always_comb begin
    ev_set        = '0;
    ev_set[EV_BM] = |stall_evt;
    ev_set[EV_PE] = ~err_sync_n[1];
    ev_set[EV_SE] = ~err_sync_n[0];
  end

  assign req_masked_o = req_i & ~locked;
  assign frame_ok_o   = ~frame_ni & ~|(gnt_i & locked);

  bec_csr_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .wr_i      (csr_wr_i),
    .wdata_i   (csr_wdata_i),
    .ev_set_i  (ev_set),
    .strap_hb_i(strap_hb_i),
    .strap_pb_i(strap_pb_i),
    .rdata_o   (csr_rdata_o),
    .irq_o     (irq_o)
  );

  // R9: a stall event is followed by the stalled-master flag in the word
  p_stall_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (|stall_evt) |=> csr_rdata_o[STAT_LSB + EV_BM]);
  // R11: soft reset never disturbs the stalled-master flag
  p_soft_keeps_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (arb_soft_rst_i && csr_rdata_o[STAT_LSB + EV_BM] && !csr_wr_i) |=> csr_rdata_o[STAT_LSB + EV_BM]);
endmodule

// File: tb/sim_bridge_err_csr.sv
module sim_bridge_err_csr;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        csr_wr_i;
  logic [31:0] csr_wdata_i;
  logic [31:0] csr_rdata_o;
  logic        irq_o;
  logic        perr_ni, serr_ni;
  logic [1:0]  strap_hb_i, strap_pb_i;
  logic [1:0]  req_i, gnt_i, req_masked_o;
  logic        frame_ni, arb_soft_rst_i, frame_ok_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bridge_err_csr #(.NUM_REQ(2), .IDLE_LIMIT(16), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .csr_wr_i(csr_wr_i), .csr_wdata_i(csr_wdata_i),
    .csr_rdata_o(csr_rdata_o), .irq_o(irq_o), .perr_ni(perr_ni), .serr_ni(serr_ni),
    .strap_hb_i(strap_hb_i), .strap_pb_i(strap_pb_i), .req_i(req_i), .gnt_i(gnt_i),
    .frame_ni(frame_ni), .arb_soft_rst_i(arb_soft_rst_i), .req_masked_o(req_masked_o),
    .frame_ok_o(frame_ok_o));

  // wdata, expected readback, expected irq (straps 01 / 10)
  localparam logic [64:0] VECS [0:5] = '{
    {32'h0000_0000, 32'h0204_0000, 1'b0},
    {32'hFFFF_FFFF, 32'h0204_7001, 1'b0},
    {32'h0000_4000, 32'h0204_4000, 1'b0},
    {32'h8D08_8FFE, 32'h0204_0000, 1'b0},
    {32'h0000_2001, 32'h0204_2001, 1'b0},
    {32'h0000_1000, 32'h0204_1000, 1'b0}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input logic [31:0] exp);
    chk(csr_rdata_o === exp, tag, csr_rdata_o, exp);
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    chk(act === exp, tag, {31'd0, act}, {31'd0, exp});
  endtask

  task automatic csr_write(input logic [31:0] d);
    csr_wr_i = 1'b1; csr_wdata_i = d;
    @(negedge clk);
    csr_wr_i = 1'b0; csr_wdata_i = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; csr_wr_i = 1'b0; csr_wdata_i = '0;
    perr_ni = 1'b1; serr_ni = 1'b1; strap_hb_i = 2'b01; strap_pb_i = 2'b10;
    req_i = '0; gnt_i = '0; frame_ni = 1'b1; arb_soft_rst_i = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    idle(6);

    // R1 reset state
    chk_word("R1 reset word", 32'h0204_0001);
    chk_bit("R1 irq after reset", irq_o, 1'b0);
    req_i = 2'b11; #1;
    chk(req_masked_o === 2'b11, "R1 no mask", {30'd0, req_masked_o}, 32'd3);
    req_i = 2'b00;

    // R13 / R7 vector walk
    for (int i = 0; i < 6; i++) begin
      csr_write(VECS[i][64:33]);
      chk_word("R13 R7 vector readback", VECS[i][32:1]);
      chk_bit("R7 vector irq", irq_o, VECS[i][0]);
    end
    csr_write(32'h0000_0001);

    // R2 straps ignored after load
    strap_hb_i = 2'b11; strap_pb_i = 2'b00;
    idle(3);
    chk_word("R2 straps frozen", 32'h0204_0001);
    strap_hb_i = 2'b01; strap_pb_i = 2'b10;

    // R12 frame passes when nothing is masked
    frame_ni = 1'b0; gnt_i = 2'b01; #1;
    chk_bit("R12 frame accepted", frame_ok_o, 1'b1);
    frame_ni = 1'b1; gnt_i = 2'b00;

    // R3 parity pulse through synchronizer
    csr_write(32'h0000_2001);
    perr_ni = 1'b0;
    @(negedge clk);
    perr_ni = 1'b1;
    @(negedge clk);
    chk_word("R3 not yet visible", 32'h0204_2001);
    @(negedge clk);
    chk_word("R3 parity flag", 32'h2204_2001);
    chk_bit("R7 parity irq", irq_o, 1'b1);
    idle(20);
    chk_bit("R8 irq held", irq_o, 1'b1);
    csr_write(32'h0000_2001);
    chk_word("R5 write zero keeps flag", 32'h2204_2001);
    csr_write(32'h2000_2001);
    chk_word("R5 write one clears", 32'h0204_2001);
    chk_bit("R8 irq drops on clear", irq_o, 1'b0);

    // R4 system error with its enable off
    serr_ni = 1'b0;
    @(negedge clk);
    serr_ni = 1'b1;
    idle(2);
    chk_word("R4 system flag", 32'h1204_2001);
    chk_bit("R7 irq gated by enable", irq_o, 1'b0);
    csr_write(32'h0000_1001);
    chk_bit("R7 irq when enabled", irq_o, 1'b1);
    csr_write(32'h1000_1001);
    chk_word("R4 cleared", 32'h0204_1001);

    // R6 set beats clear
    perr_ni = 1'b0;
    idle(4);
    csr_write(32'h2000_1001);
    chk_word("R6 set wins", 32'h2204_1001);
    perr_ni = 1'b1;
    idle(3);
    csr_write(32'h2000_1001);
    chk_word("R6 clear after release", 32'h0204_1001);

    // R9 stall detection, count restarted by frame activity
    csr_write(32'h0000_4001);
    req_i = 2'b01; gnt_i = 2'b01;
    idle(10);
    frame_ni = 1'b0;
    @(negedge clk);
    frame_ni = 1'b1;
    idle(15);
    chk_bit("R9 no stall at limit-1", req_masked_o[0], 1'b1);
    chk_word("R9 flag clear at limit-1", 32'h0204_4001);
    @(negedge clk);
    chk_bit("R9 masked at limit", req_masked_o[0], 1'b0);
    chk_word("R9 stall flag", 32'h4204_4001);
    chk_bit("R9 stall irq", irq_o, 1'b1);

    // R12 frame ignored while locked requester is granted
    frame_ni = 1'b0; #1;
    chk_bit("R12 frame blocked", frame_ok_o, 1'b0);
    gnt_i = 2'b10; #1;
    chk_bit("R12 other master ok", frame_ok_o, 1'b1);
    frame_ni = 1'b1; gnt_i = 2'b01;

    // R11 soft reset
    arb_soft_rst_i = 1'b1;
    @(negedge clk);
    arb_soft_rst_i = 1'b0;
    chk_bit("R11 soft release", req_masked_o[0], 1'b1);
    chk_word("R11 flag kept", 32'h4204_4001);

    // R10 release by dropping request
    idle(16);
    chk_bit("R10 relocked", req_masked_o[0], 1'b0);
    req_i = 2'b00;
    @(negedge clk);
    req_i = 2'b01; gnt_i = 2'b00; #1;
    chk_bit("R10 release on drop", req_masked_o[0], 1'b1);

    // R10 / R1 hard reset releases the lock
    gnt_i = 2'b01;
    idle(16);
    chk_bit("R10 locked before reset", req_masked_o[0], 1'b0);
    rst_ni = 1'b0; #1;
    chk_bit("R10 hard reset release", req_masked_o[0], 1'b1);
    chk_word("R1 word during reset", 32'h0000_0001);
    req_i = '0; gnt_i = '0;
    strap_hb_i = 2'b00; strap_pb_i = 2'b11;
    idle(2);
    rst_ni = 1'b1;
    idle(6);
    chk_word("R2 new straps", 32'h0104_0001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule